// File: doc/BRIEF.md
# Buffer Store Occupancy Controller

This block supervises a store that holds a bounded number of items. An entry sensor produces a pulse for each item that arrives, and an exit sensor produces a pulse for each item that leaves. A three-state control machine turns these pulses into increment and decrement strobes for a saturating occupancy counter. Two threshold comparators watch the counter. One raises a full flag at capacity. The other raises a low flag below a lower threshold.

The machine drives a conveyor motor enable and a low-level lamp. After reset it waits in an idle state with every output low. The operator closes the operate switch and presses the calibrate button together, which clears the counter and starts the running state. While running, the motor is on. If an item arrives while the store is full, the machine drops into a halted state. There the motor and every other output are off at once. Only an exit pulse brings the machine back to running.

All inputs are synchronous to `clk`. Sensor pulses are assumed debounced and one clock wide. The strobes, the motor enable and the lamp are combinational functions of the current state and the inputs. The occupancy count changes on the following clock edge. No data streams through the block, so every pin is a plain control or status signal.

Top module: `store_occ_ctrl`

## Requirements
- R1: With `rst` high at a clock edge, the machine enters idle and `occupancy` becomes 0. In idle with no inputs, `motor_en`, `low_lamp`, `inc_strobe` and `dec_strobe` are all 0.
- R2: In idle, every output stays 0 and `occupancy` is unchanged, whatever the entry and exit pulses do. The machine stays idle unless `run_sw` and `cal_btn` are both 1.
- R3: In idle, `run_sw`=1 with `cal_btn`=1 clears `occupancy` to 0 and moves the machine to running on the next edge. `motor_en` is 0 during that cycle and 1 afterwards.
- R4: In running, `motor_en` is 1 and `inc_strobe` equals `enter_pulse`. An entry pulse below capacity raises `occupancy` by one at the next edge.
- R5: In running, an exit pulse sets `dec_strobe`. If `occupancy` is above 0, it drops by one at the next edge.
- R6: When `inc_strobe` and `dec_strobe` are both 1 in the same cycle, `occupancy` does not change.
- R7: `full_flag` is 1 exactly when `occupancy` equals CAP (default 30). While running at CAP with no entry, `motor_en` stays 1. An entry pulse at CAP asserts `inc_strobe` but not `dec_strobe`, leaves `occupancy` at CAP, and moves the machine to halted.
- R8: In halted, `motor_en`, `low_lamp`, `inc_strobe` and `dec_strobe` are all 0. Entry pulses change nothing. An exit pulse returns the machine to running without changing `occupancy`.
- R9: `low_lamp` is 1 only in running, and there it is 1 exactly when `occupancy` is below LOW_TH (default 10). So it is 1 at 9 and 0 at 10.
- R10: A decrement at `occupancy` 0 is ignored, and the count stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_sw | input | 1 | Operate switch |
| cal_btn | input | 1 | Calibrate pushbutton |
| enter_pulse | input | 1 | One-cycle pulse per arriving item |
| exit_pulse | input | 1 | One-cycle pulse per leaving item |
| motor_en | output | 1 | Conveyor motor enable |
| low_lamp | output | 1 | Low-level lamp |
| inc_strobe | output | 1 | Counter increment strobe |
| dec_strobe | output | 1 | Counter decrement strobe |
| full_flag | output | 1 | Occupancy equals capacity |
| occupancy | output | CNT_W | Current item count, CNT_W = $clog2(CAP+1) |

## Verification
The bench applies isolated entry pulses, isolated exit pulses, and simultaneous entry and exit pulses. Comparing these shows that the counter steps by one in each direction and holds when both strobes fire. It walks the count across the lamp threshold (9, 10, back to 9) and up to capacity. This separates the two comparators and shows that an entry at full halts the motor without counting. Sensor pulses sent in idle and in halted, and an exit sent at zero, show that each is ignored. The release from halted is checked to leave the count untouched.

// File: rtl/store_occ_pkg.sv
package store_occ_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_HALT = 2'b11
  } occ_state_e;

  typedef struct packed {
    logic motor;
    logic lamp;
    logic inc;
    logic dec;
    logic clr;
  } occ_cmd_t;

endpackage

// File: rtl/occ_threshold.sv
module occ_threshold #(
  parameter int W      = 5,
  parameter int LIMIT  = 30,
  parameter bit EQ_CMP = 1'b1
) (
  input  logic [W-1:0] value,
  output logic         hit
);
  localparam logic [W-1:0] LIM_V = W'(LIMIT);

  generate
    if (EQ_CMP) begin : g_eq
      assign hit = (value == LIM_V);
    end else begin : g_lt
      assign hit = (value < LIM_V);
    end
  endgenerate
endmodule

// File: rtl/occ_counter.sv
module occ_counter #(
  parameter int CAP = 30,
  localparam int W  = $clog2(CAP + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = W'(CAP);

  logic [W-1:0] cnt_q;
  logic         up_ok, dn_ok;

  assign up_ok = inc && !dec && (cnt_q != TOP);
  assign dn_ok = dec && !inc && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (up_ok) cnt_q <= cnt_q + 1'b1;
    else if (dn_ok) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt = cnt_q;

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TOP);

  // R6
  both_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && dec && !clr) |=> $stable(cnt_q));

  // R10
  floor_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !inc && !clr) |=> (cnt_q == '0));

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr) |=> (int'(cnt_q) - int'($past(cnt_q)) <= 1 &&
                int'($past(cnt_q)) - int'(cnt_q) <= 1));
endmodule

// File: rtl/occ_ctrl.sv
module occ_ctrl
  import store_occ_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run_sw,
  input  logic       cal_btn,
  input  logic       enter_p,
  input  logic       exit_p,
  input  logic       full,
  input  logic       low,
  output occ_cmd_t   cmd,
  output occ_state_e state
);
  occ_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    cmd  = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (run_sw && cal_btn) begin
          st_d    = ST_RUN;
          cmd.clr = 1'b1;
        end
      end
      ST_RUN: begin
        cmd.motor = 1'b1;
        cmd.inc   = enter_p;
        if (enter_p && full) begin
          st_d = ST_HALT;
        end else begin
          cmd.dec  = exit_p;
          cmd.lamp = low;
        end
      end
      ST_HALT: begin
        if (exit_p) st_d = ST_RUN;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  assign state = st_q;

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HALT && !exit_p) |=> (st_q == ST_HALT));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && !(run_sw && cal_btn)) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/store_occ_ctrl.sv
module store_occ_ctrl #(
  parameter int CAP    = 30,
  parameter int LOW_TH = 10,
  localparam int CNT_W = $clog2(CAP + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_sw,
  input  logic             cal_btn,
  input  logic             enter_pulse,
  input  logic             exit_pulse,
  output logic             motor_en,
  output logic             low_lamp,
  output logic             inc_strobe,
  output logic             dec_strobe,
  output logic             full_flag,
  output logic [CNT_W-1:0] occupancy
);
  import store_occ_pkg::*;

  occ_cmd_t   cmd;
  occ_state_e state;
  logic       full_w, low_w;
  logic [CNT_W-1:0] cnt_w;

  occ_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .run_sw  (run_sw),
    .cal_btn (cal_btn),
    .enter_p (enter_pulse),
    .exit_p  (exit_pulse),
    .full    (full_w),
    .low     (low_w),
    .cmd     (cmd),
    .state   (state)
  );

  occ_counter #(.CAP(CAP)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (cmd.clr),
    .inc (cmd.inc),
    .dec (cmd.dec),
    .cnt (cnt_w)
  );

  occ_threshold #(.W(CNT_W), .LIMIT(CAP), .EQ_CMP(1'b1)) u_full_cmp (
    .value (cnt_w),
    .hit   (full_w)
  );

  occ_threshold #(.W(CNT_W), .LIMIT(LOW_TH), .EQ_CMP(1'b0)) u_low_cmp (
    .value (cnt_w),
    .hit   (low_w)
  );

  assign motor_en   = cmd.motor;
  assign low_lamp   = cmd.lamp;
  assign inc_strobe = cmd.inc;
  assign dec_strobe = cmd.dec;
  assign full_flag  = full_w;
  assign occupancy  = cnt_w;

  // R7
  full_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_strobe && full_flag) |=> !motor_en);

  // R9
  lamp_level_chk: assert property (@(posedge clk) disable iff (rst)
    low_lamp |-> (motor_en && int'(occupancy) < LOW_TH));

  // R3
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && run_sw && cal_btn) |=> (occupancy == '0 && motor_en));

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HALT) |-> !(motor_en || low_lamp || inc_strobe || dec_strobe));
endmodule

// File: tb/test_store_occ_ctrl.sv
module test_store_occ_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CAP = 30;
  localparam int LOW_TH = 10;
  localparam int CNT_W = $clog2(CAP + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_sw = 1'b0, cal_btn = 1'b0, enter_pulse = 1'b0, exit_pulse = 1'b0;
  logic motor_en, low_lamp, inc_strobe, dec_strobe, full_flag;
  logic [CNT_W-1:0] occupancy;

  int total = 0;
  int bad = 0;
  logic m_s, l_s, i_s, d_s;

  always #(CLK_PERIOD/2) clk = ~clk;

  store_occ_ctrl #(.CAP(CAP), .LOW_TH(LOW_TH)) i_store_occ_ctrl (
    .clk(clk), .rst(rst), .run_sw(run_sw), .cal_btn(cal_btn),
    .enter_pulse(enter_pulse), .exit_pulse(exit_pulse),
    .motor_en(motor_en), .low_lamp(low_lamp), .inc_strobe(inc_strobe),
    .dec_strobe(dec_strobe), .full_flag(full_flag), .occupancy(occupancy)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, capture combinational outputs, then let the edge pass
  task automatic cyc(input logic c, input logic d, input logic e, input logic h);
    @(negedge clk);
    run_sw = c; cal_btn = d; enter_pulse = e; exit_pulse = h;
    #1;
    m_s = motor_en; l_s = low_lamp; i_s = inc_strobe; d_s = dec_strobe;
    @(posedge clk);
    #1;
    run_sw = 1'b0; cal_btn = 1'b0; enter_pulse = 1'b0; exit_pulse = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 count", int'(occupancy), 0);
    check("R1 outputs", int'({motor_en, low_lamp, inc_strobe, dec_strobe}), 0);
  endtask

  task automatic t_idle;
    cyc(1, 0, 1, 0);
    check("R2 inc in idle", int'(i_s), 0);
    check("R2 count", int'(occupancy), 0);
    cyc(0, 1, 0, 1);
    check("R2 dec in idle", int'(d_s), 0);
    cyc(0, 0, 0, 0);
    check("R2 still idle", int'({m_s, l_s}), 0);
  endtask

  task automatic t_start;
    cyc(1, 1, 0, 0);
    check("R3 motor during start", int'(m_s), 0);
    check("R3 count cleared", int'(occupancy), 0);
    cyc(0, 0, 0, 0);
    check("R3 running", int'(m_s), 1);
  endtask

  task automatic t_floor;
    cyc(0, 0, 0, 1);
    check("R5 dec strobe", int'(d_s), 1);
    check("R10 stays zero", int'(occupancy), 0);
    cyc(0, 0, 1, 1);
    check("R6 both strobes", int'({i_s, d_s}), 3);
    check("R6 hold at zero", int'(occupancy), 0);
  endtask

  task automatic t_low_edge;
    for (int k = 0; k < 9; k++) cyc(0, 0, 1, 0);
    check("R4 count after 9", int'(occupancy), 9);
    check("R4 inc strobe", int'(i_s), 1);
    cyc(0, 0, 0, 0);
    check("R9 lamp at 9", int'(l_s), 1);
    cyc(0, 0, 1, 0);
    check("R4 count 10", int'(occupancy), 10);
    cyc(0, 0, 0, 0);
    check("R9 lamp at 10", int'(l_s), 0);
    cyc(0, 0, 0, 1);
    check("R5 count 9", int'(occupancy), 9);
    cyc(0, 0, 1, 1);
    check("R6 hold at 9", int'(occupancy), 9);
    check("R9 lamp back at 9", int'(l_s), 1);
  endtask

  task automatic t_fill_halt;
    for (int k = 0; k < 21; k++) cyc(0, 0, 1, 0);
    check("R4 count full", int'(occupancy), CAP);
    cyc(0, 0, 0, 0);
    check("R7 full flag", int'(full_flag), 1);
    check("R7 motor at cap", int'(m_s), 1);
    cyc(0, 0, 1, 0);
    check("R7 strobes at cap", int'({i_s, d_s}), 2);
    check("R7 saturate", int'(occupancy), CAP);
    cyc(0, 0, 0, 0);
    check("R8 halted outputs", int'({m_s, l_s, i_s, d_s}), 0);
    cyc(0, 0, 1, 0);
    check("R8 entry ignored", int'({m_s, i_s}), 0);
    check("R8 count kept", int'(occupancy), CAP);
    cyc(0, 0, 0, 1);
    check("R8 exit no dec", int'(d_s), 0);
    check("R8 count on release", int'(occupancy), CAP);
    cyc(0, 0, 0, 0);
    check("R8 running again", int'(m_s), 1);
    cyc(0, 0, 0, 1);
    check("R5 count 29", int'(occupancy), CAP - 1);
    check("R7 full cleared", int'(full_flag), 0);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_start();
    t_floor();
    t_low_edge();
    t_fill_halt();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule